// File: doc/BRIEF.md
# Binary-Tree Carry-Lookahead Adder

This block adds two 16-bit unsigned operands and a carry-in and returns a 16-bit sum with a carry-out. It has no clock and no registers: the outputs follow the inputs through combinational logic alone. It is meant to sit inside a larger datapath wherever a plain addition is needed and the carry path must be shorter than a ripple chain.

The structure is regular. One single-bit sum cell per bit position produces a generate/propagate pair and, once its carry arrives, the sum bit. Above the sum cells sits a balanced radix-2 tree of lookahead cells, with 8, then 4, then 2, then 1 cells. Each cell joins the generate/propagate pairs of exactly two neighbouring groups, a less significant one and a more significant one. On the way back down, each cell hands the incoming carry unchanged to its lower child and hands a computed carry to its upper child. The external carry-in enters at the root and so becomes the carry into bit 0. A separate small unit combines the root's group pair with the carry-in to form the carry-out.

The width is a parameter and must be a power of two. The default is 16.

Top module: `cla_tree_adder`

## Requirements
- R1: For every input, {carry_o, sum_o} equals the 17-bit value a_i + b_i + carry_i.
- R2: sum_o bit 0 equals a_i bit 0 XOR b_i bit 0 XOR carry_i. The carry-in is the carry into the least significant position.
- R3: With a_i = 16'hFFFF, b_i = 16'h0000 and carry_i = 1, the carry travels through every tree level: sum_o = 16'h0000 and carry_o = 1.
- R4: When b_i is the bitwise complement of a_i, sum_o is 16'hFFFF with carry_o = 0 if carry_i = 0, and sum_o is 16'h0000 with carry_o = 1 if carry_i = 1.
- R5: With both operands zero, sum_o equals carry_i in bit 0 and zero in all other bits, and carry_o = 0.
- R6: carry_o is 1 whenever a_i + b_i alone exceeds 16'hFFFF, whatever carry_i is. For example, 16'h8000 + 16'h8000 gives carry_o = 1 and sum_o = carry_i.
- R7: With alternating-bit operands (16'hAAAA and 16'h5555 in either order, or each added to itself), the result follows R1 for both values of carry_i.
- R8: The outputs settle within the same cycle in which the inputs change. No clock edge is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| carry_o | output | 1 | Carry out of the most significant bit |

## Verification
Two results can depend on the same input in one evaluation: the carry-out and the low sum bit. Both change when a carry-in travels the full propagate path down the tree and, through the root, out of the top. The bench provokes this with all-ones and complementary operands while it toggles carry_i between vectors. It then judges sum_o and carry_o together against a 17-bit addition computed in the bench, so both must flip in the same sample. Random vectors afterwards cover mixed generate and propagate patterns across the subtrees.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Generate/propagate pair carried up the lookahead tree.
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;
endpackage

// File: rtl/cla_sum_cell.sv
module cla_sum_cell
  import cla_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic c,
  output gp_t  gp,
  output logic s
);
  logic half;

  always_comb begin
    half = a ^ b;
    gp.g = a & b;
    gp.p = half;
    s    = half ^ c;
  end
endmodule

// File: rtl/cla_merge_cell.sv
module cla_merge_cell
  import cla_pkg::*;
(
  input  gp_t  lo,
  input  gp_t  hi,
  input  logic c_in,
  output gp_t  grp,
  output logic c_lo,
  output logic c_hi
);
  always_comb begin
    grp.g = hi.g | (hi.p & lo.g);
    grp.p = hi.p & lo.p;
    c_lo  = c_in;
    c_hi  = lo.g | (lo.p & c_in);
  end
endmodule

// File: rtl/cla_carry_out.sv
module cla_carry_out
  import cla_pkg::*;
(
  input  gp_t  root,
  input  logic cin,
  output logic cout
);
  always_comb cout = root.g | (root.p & cin);
endmodule

// File: rtl/cla_tree_adder.sv
module cla_tree_adder
  import cla_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  // Heap numbering: node 1 is the root, node k has children 2k (low)
  // and 2k+1 (high); leaves WIDTH..2*WIDTH-1 are the bit cells.
  localparam int NODES = 2 * WIDTH - 1;

  gp_t  gp_n [1:NODES];
  logic c_n  [1:NODES];

  assign c_n[1] = carry_i;

  for (genvar k = 1; k < WIDTH; k++) begin : g_tree
    cla_merge_cell u_merge (
      .lo   (gp_n[2*k]),
      .hi   (gp_n[2*k+1]),
      .c_in (c_n[k]),
      .grp  (gp_n[k]),
      .c_lo (c_n[2*k]),
      .c_hi (c_n[2*k+1])
    );
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bits
    cla_sum_cell u_sum (
      .a  (a_i[i]),
      .b  (b_i[i]),
      .c  (c_n[WIDTH+i]),
      .gp (gp_n[WIDTH+i]),
      .s  (sum_o[i])
    );
  end

  cla_carry_out u_cout (
    .root (gp_n[1]),
    .cin  (carry_i),
    .cout (carry_o)
  );
endmodule

// File: rtl/cla_tree_adder_chk.sv
module cla_tree_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o
);
  logic [WIDTH:0] ref_total;

  always_comb begin
    ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};
    // R1
    sum_match_chk: assert ({carry_o, sum_o} == ref_total);
    // R2
    bit0_chk: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ carry_i));
    if (a_i == ~b_i) begin
      // R4
      complement_chk: assert (carry_o == carry_i && sum_o == {WIDTH{~carry_i}});
    end
    if (a_i == '0 && b_i == '0) begin
      // R5
      zero_chk: assert (carry_o == 1'b0 && sum_o == {{(WIDTH-1){1'b0}}, carry_i});
    end
    if (({1'b0, a_i} + {1'b0, b_i}) > {1'b0, {WIDTH{1'b1}}}) begin
      // R6
      overflow_chk: assert (carry_o);
    end
  end
endmodule

bind cla_tree_adder cla_tree_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .carry_i (carry_i),
  .sum_o   (sum_o),
  .carry_o (carry_o)
);

// File: tb/cla_tree_adder_bench.sv
`timescale 1ns/1ps
module cla_tree_adder_bench;
  logic        clk = 1'b0;
  logic [15:0] a, b;
  logic        cin;
  logic [15:0] sum;
  logic        cout;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cla_tree_adder u_cla_tree_adder (
    .a_i(a), .b_i(b), .carry_i(cin), .sum_o(sum), .carry_o(cout)
  );

  // Drive at a rising edge, sample at the following falling edge.
  task automatic apply(input logic [15:0] x, input logic [15:0] y,
                       input logic c, input string req);
    logic [16:0] exp;
    @(posedge clk);
    a = x; b = y; cin = c;
    exp = {1'b0, x} + {1'b0, y} + {16'b0, c};
    @(negedge clk);
    n_checks++;
    if ({cout, sum} !== exp) begin
      n_errors++;
      $display("FAIL %s: a=%h b=%h cin=%b actual=%h expected=%h",
               req, x, y, c, {cout, sum}, exp);
    end
  endtask

  task automatic t_zero();        // R5
    apply(16'h0000, 16'h0000, 1'b0, "R5");
    apply(16'h0000, 16'h0000, 1'b1, "R5");
  endtask

  task automatic t_bit0();        // R2
    apply(16'h0001, 16'h0000, 1'b1, "R2");
    apply(16'h0001, 16'h0001, 1'b0, "R2");
    apply(16'h1230, 16'h0000, 1'b1, "R2");
  endtask

  task automatic t_all_ones();    // R3
    apply(16'hFFFF, 16'h0000, 1'b1, "R3");
    apply(16'h0000, 16'hFFFF, 1'b1, "R3");
    apply(16'hFFFF, 16'h0001, 1'b0, "R3");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R3");
  endtask

  task automatic t_complement();  // R4
    apply(16'h1234, 16'hEDCB, 1'b0, "R4");
    apply(16'h1234, 16'hEDCB, 1'b1, "R4");
    apply(16'h00FF, 16'hFF00, 1'b1, "R4");
    apply(16'h00FF, 16'hFF00, 1'b0, "R4");
  endtask

  task automatic t_overflow();    // R6
    apply(16'h8000, 16'h8000, 1'b0, "R6");
    apply(16'h8000, 16'h8000, 1'b1, "R6");
    apply(16'hC000, 16'h7FFF, 1'b0, "R6");
  endtask

  task automatic t_alternating(); // R7
    for (int c = 0; c < 2; c++) begin
      apply(16'hAAAA, 16'h5555, c[0], "R7");
      apply(16'h5555, 16'hAAAA, c[0], "R7");
      apply(16'hAAAA, 16'hAAAA, c[0], "R7");
      apply(16'h5555, 16'h5555, c[0], "R7");
    end
  endtask

  task automatic t_same_cycle();  // R8: carry-in toggled each cycle, no settling gap
    for (int k = 0; k < 8; k++)
      apply(16'h7FFF, 16'h8000, k[0], "R8");
  endtask

  task automatic t_random();      // R1
    for (int k = 0; k < 400; k++)
      apply(16'($urandom), 16'($urandom), 1'($urandom), "R1");
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    t_zero();
    t_bit0();
    t_all_ones();
    t_complement();
    t_overflow();
    t_alternating();
    t_same_cycle();
    t_random();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule